// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath slice. It takes two `WIDTH`-bit operands, a 4-bit operation select, a carry input and two serial fill bits. It returns one `WIDTH`-bit result and a carry output. It is meant to sit between a register file's read ports and a destination register's load input. The result settles within the same cycle, and the surrounding logic captures it on its own clock edge.

The upper two select bits pick which of four sources drives the result:

- an adder whose second operand is steered by the lower select bits,
- a bitwise logic stage,
- a one-bit right shifter,
- a one-bit left shifter.

Eight arithmetic operations come from the single adder, by combining the operand steering with the carry input. These are add, add plus one, subtract with borrow, subtract, transfer, increment, decrement and transfer again.

Top module: `alu_shift_unit`

## Requirements
- R1: With `op_sel[3:2]`=00 and `op_sel[1:0]`=00, `result` = (A + B + `carry_in`) mod 2^WIDTH, and `carry_out` is bit WIDTH of that full sum.
- R2: With `op_sel`=0001, the adder adds the bitwise complement of B. So `result` = A + ~B + `carry_in`, which is A − B when `carry_in`=1 and A − B − 1 when `carry_in`=0. `carry_out` is the top carry of that sum.
- R3: With `op_sel`=0010, the second operand is zero. So `result` = A + `carry_in` (transfer or increment), and `carry_out` is 1 only when A is all ones and `carry_in`=1.
- R4: With `op_sel`=0011, the second operand is all ones. So `result` = A − 1 + `carry_in` (decrement, or transfer when `carry_in`=1), and `carry_out` is 1 unless A=0 and `carry_in`=0.
- R5: With `op_sel[3:2]`=01, `result` is A AND B for `op_sel[1:0]`=00, A OR B for 01, A XOR B for 10, and NOT A for 11.
- R6: With `op_sel[3:2]`=10, `result` = {`fill_msb`, A[WIDTH-1:1]}, which is a right shift by one.
- R7: With `op_sel[3:2]`=11, `result` = {A[WIDTH-2:0], `fill_lsb`}, which is a left shift by one.
- R8: `carry_out` is 0 whenever `op_sel[3:2]` is not 00. `carry_in` has no effect on `result` outside arithmetic mode.
- R9: The serial fill inputs have no effect on `result` or `carry_out` in arithmetic or logic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand; the only operand of shifts and of NOT |
| b_in | input | WIDTH | Second operand |
| op_sel | input | 4 | [3:2] picks the source, [1:0] picks the operation within it |
| carry_in | input | 1 | Adder carry input |
| fill_msb | input | 1 | Bit shifted into the top position on a right shift |
| fill_lsb | input | 1 | Bit shifted into bit 0 on a left shift |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Adder carry in arithmetic mode, else 0 |

## Verification
The embedded assertions assume that every input is a defined 0 or 1 whenever the combinational outputs are examined. They also assume that the checked relations are only meaningful once the inputs have settled. The stimulus applies one complete input vector per cycle, away from the sampling edge, and never leaves an input undriven. All sixteen select codes are swept with both carry values and both fill values. The sweep includes the all-zero and all-ones operands where the decrement and increment carries flip.

// File: rtl/alu_shift_pkg.sv
// Shared types for the arithmetic/logic/shift unit.
// Assumes nothing beyond a 4-bit select split into source and function.
package alu_shift_pkg;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'b00,
        SRC_LOGIC = 2'b01,
        SRC_SHR   = 2'b10,
        SRC_SHL   = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        LF_AND = 2'b00,
        LF_OR  = 2'b01,
        LF_XOR = 2'b10,
        LF_NOT = 2'b11
    } logic_fn_e;

    typedef enum logic [1:0] {
        Y_B    = 2'b00,
        Y_NOTB = 2'b01,
        Y_ZERO = 2'b10,
        Y_ONES = 2'b11
    } y_sel_e;

endpackage

// File: rtl/alu_arith.sv
// Arithmetic stage: a single adder whose second operand is steered among
// B, ~B, zero and all-ones; together with the carry input this yields
// eight operations. Assumes inputs are settled, defined values.
module alu_arith
    import alu_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int SUMW = WIDTH + 1;

    logic [WIDTH-1:0] y_op;
    logic [SUMW-1:0]  full;

    // Steer the adder's second operand from the function code.
    always_comb begin
        unique case (y_sel_e'(fn))
            Y_B:     y_op = b;
            Y_NOTB:  y_op = ~b;
            Y_ZERO:  y_op = '0;
            default: y_op = '1;
        endcase
    end

    // Single ripple-style sum with carry in; top bit is the carry out.
    always_comb begin
        full = {1'b0, a} + {1'b0, y_op} + {{WIDTH{1'b0}}, cin};
        sum  = full[WIDTH-1:0];
        cout = full[WIDTH];
    end

    // Check the adder against independent arithmetic views of each mode.
    always_comb begin
        if (fn == 2'b01 && cin) begin
            a_r2_true_subtract: assert (sum == WIDTH'(a - b));
        end
        if (fn == 2'b10 && !cin) begin
            a_r3_transfer_no_carry: assert (sum == a && !cout);
        end
        if (fn == 2'b11 && !cin) begin
            a_r4_decrement_borrow: assert (sum == WIDTH'(a - 1'b1) && cout == (a != '0));
        end
    end

endmodule

// File: rtl/alu_logic.sv
// Logic stage: AND, OR, XOR of A and B, or complement of A.
// Assumes defined inputs; no carry involvement.
module alu_logic
    import alu_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] res
);

    // Bitwise function selected by the lower select bits.
    always_comb begin
        unique case (logic_fn_e'(fn))
            LF_AND:  res = a & b;
            LF_OR:   res = a | b;
            LF_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
    end

    // Complement output must be the exact inverse of A.
    always_comb begin
        if (fn == 2'b11) begin
            a_r5_complement: assert ((res ^ a) == {WIDTH{1'b1}});
        end
    end

endmodule

// File: rtl/alu_shift1.sv
// One-bit shifter; SHIFT_LEFT picks the direction at elaboration.
// The vacated end takes the serial fill bit. Assumes WIDTH >= 2.
module alu_shift1 #(
    parameter int WIDTH      = 8,
    parameter bit SHIFT_LEFT = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic             fill,
    output logic [WIDTH-1:0] res
);

    localparam int TOP = WIDTH - 1;

    generate
        if (SHIFT_LEFT) begin : g_left
            // Each bit takes its lower neighbour; bit 0 takes the fill.
            assign res[0] = fill;
            for (genvar i = 1; i < WIDTH; i++) begin : g_bit
                assign res[i] = a[i-1];
            end
            // Left result must equal A shifted up with the fill appended.
            always_comb begin
                a_r7_left_shift: assert (res == {a[TOP-1:0], fill});
            end
        end else begin : g_right
            // Each bit takes its upper neighbour; top bit takes the fill.
            assign res[TOP] = fill;
            for (genvar i = 0; i < TOP; i++) begin : g_bit
                assign res[i] = a[i+1];
            end
            // Right result must equal A shifted down with the fill on top.
            always_comb begin
                a_r6_right_shift: assert (res == {fill, a[TOP:1]});
            end
        end
    endgenerate

endmodule

// File: rtl/alu_shift_unit.sv
// Top of the arithmetic/logic/shift unit. op_sel[3:2] selects the source
// (arith, logic, shift right, shift left); op_sel[1:0] the function.
// Purely combinational; assumes the caller registers the result.
module alu_shift_unit
    import alu_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [3:0]       op_sel,
    input  logic             carry_in,
    input  logic             fill_msb,
    input  logic             fill_lsb,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    logic [WIDTH-1:0] arith_res;
    logic             arith_cout;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shr_res;
    logic [WIDTH-1:0] shl_res;
    src_e             src;

    assign src = src_e'(op_sel[3:2]);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a    (a_in),
        .b    (b_in),
        .fn   (op_sel[1:0]),
        .cin  (carry_in),
        .sum  (arith_res),
        .cout (arith_cout)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (a_in),
        .b   (b_in),
        .fn  (op_sel[1:0]),
        .res (logic_res)
    );

    alu_shift1 #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b0)) u_shr (
        .a    (a_in),
        .fill (fill_msb),
        .res  (shr_res)
    );

    alu_shift1 #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b1)) u_shl (
        .a    (a_in),
        .fill (fill_lsb),
        .res  (shl_res)
    );

    // Output multiplexer: pick one source; carry only from the adder.
    always_comb begin
        carry_out = 1'b0;
        unique case (src)
            SRC_ARITH: begin
                result    = arith_res;
                carry_out = arith_cout;
            end
            SRC_LOGIC: result = logic_res;
            SRC_SHR:   result = shr_res;
            default:   result = shl_res;
        endcase
    end

    // Non-arithmetic sources never report a carry; arith add is exact.
    always_comb begin
        if (op_sel[3:2] != 2'b00) begin
            a_r8_no_carry_outside_arith: assert (!carry_out);
        end
        if (op_sel == 4'b0000) begin
            a_r1_add: assert ({carry_out, result} == ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}));
        end
    end

endmodule

// File: tb/alu_shift_unit_test.sv
// Scoreboard bench: driver pushes expected results, monitor compares.
module alu_shift_unit_test;

    localparam int WIDTH = 8;
    localparam int MAXV  = (1 << WIDTH) - 1;

    typedef struct {
        logic [WIDTH-1:0] res;
        logic             cout;
        string            tag;
        logic [3:0]       sel;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] a_in = '0;
    logic [WIDTH-1:0] b_in = '0;
    logic [3:0]       op_sel = '0;
    logic             carry_in = 1'b0;
    logic             fill_msb = 1'b0;
    logic             fill_lsb = 1'b0;
    logic [WIDTH-1:0] result;
    logic             carry_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    alu_shift_unit #(.WIDTH(WIDTH)) uut (
        .a_in      (a_in),
        .b_in      (b_in),
        .op_sel    (op_sel),
        .carry_in  (carry_in),
        .fill_msb  (fill_msb),
        .fill_lsb  (fill_lsb),
        .result    (result),
        .carry_out (carry_out)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                   input logic [3:0] s, input logic ci,
                                   input logic fm, input logic fl, input string force_tag);
        exp_t e;
        int   tot;
        e.sel = s; e.a = a; e.b = b; e.cout = 1'b0;
        case (s[3:2])
            2'b00: begin
                case (s[1:0])
                    2'b00: begin tot = int'(a) + int'(b) + int'(ci);          e.tag = "R1"; end
                    2'b01: begin tot = int'(a) + (MAXV - int'(b)) + int'(ci); e.tag = "R2"; end
                    2'b10: begin tot = int'(a) + int'(ci);                    e.tag = "R3"; end
                    default: begin tot = int'(a) + MAXV + int'(ci);           e.tag = "R4"; end
                endcase
                e.res  = WIDTH'(tot % (MAXV + 1));
                e.cout = (tot > MAXV);
            end
            2'b01: begin
                case (s[1:0])
                    2'b00: e.res = a & b;
                    2'b01: e.res = a | b;
                    2'b10: e.res = a ^ b;
                    default: e.res = ~a;
                endcase
                e.tag = "R5";
            end
            2'b10: begin e.res = {fm, a[WIDTH-1:1]}; e.tag = "R6"; end
            default: begin e.res = {a[WIDTH-2:0], fl}; e.tag = "R7"; end
        endcase
        if (force_tag != "") e.tag = force_tag;
        return e;
    endfunction

    // Driver: apply one vector just after a rising edge, push the expectation.
    task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic [3:0] s, input logic ci,
                         input logic fm, input logic fl, input string tag);
        @(posedge clk);
        #0.5;
        a_in = a; b_in = b; op_sel = s; carry_in = ci; fill_msb = fm; fill_lsb = fl;
        sb.push_back(model(a, b, s, ci, fm, fl, tag));
    endtask

    // Monitor: at each falling edge compare the settled outputs.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (result !== e.res || carry_out !== e.cout) begin
                n_fail++;
                $display("FAIL %s sel=%b a=%h b=%h: actual res=%h cout=%b expected res=%h cout=%b",
                         e.tag, e.sel, e.a, e.b, result, carry_out, e.res, e.cout);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        // Idle state: all-zero inputs give an add of zero.
        drive(8'h00, 8'h00, 4'b0000, 1'b0, 1'b0, 1'b0, "R1");
        // R1 add and add-plus-one, including wrap with carry out.
        drive(8'h3C, 8'h41, 4'b0000, 1'b0, 1'b0, 1'b0, "R1");
        drive(8'hFF, 8'h01, 4'b0000, 1'b0, 1'b0, 1'b0, "R1");
        drive(8'hFF, 8'hFF, 4'b0000, 1'b1, 1'b0, 1'b0, "R1");
        // R2 subtract and subtract with borrow, equal and smaller operands.
        drive(8'h50, 8'h20, 4'b0001, 1'b1, 1'b0, 1'b0, "R2");
        drive(8'h20, 8'h50, 4'b0001, 1'b1, 1'b0, 1'b0, "R2");
        drive(8'h77, 8'h77, 4'b0001, 1'b1, 1'b0, 1'b0, "R2");
        drive(8'h77, 8'h77, 4'b0001, 1'b0, 1'b0, 1'b0, "R2");
        // R3 transfer and increment, increment wrap of all ones.
        drive(8'hA5, 8'h00, 4'b0010, 1'b0, 1'b0, 1'b0, "R3");
        drive(8'hFF, 8'h00, 4'b0010, 1'b1, 1'b0, 1'b0, "R3");
        // R4 decrement of zero and of one, transfer with carry in.
        drive(8'h00, 8'h00, 4'b0011, 1'b0, 1'b0, 1'b0, "R4");
        drive(8'h01, 8'h00, 4'b0011, 1'b0, 1'b0, 1'b0, "R4");
        drive(8'h00, 8'h00, 4'b0011, 1'b1, 1'b0, 1'b0, "R4");
        // R5 each logic function.
        drive(8'hCA, 8'h6F, 4'b0100, 1'b0, 1'b0, 1'b0, "R5");
        drive(8'hCA, 8'h6F, 4'b0101, 1'b0, 1'b0, 1'b0, "R5");
        drive(8'hCA, 8'h6F, 4'b0110, 1'b0, 1'b0, 1'b0, "R5");
        drive(8'hCA, 8'h6F, 4'b0111, 1'b0, 1'b0, 1'b0, "R5");
        // R6 / R7 shifts with zero and one fill.
        drive(8'h81, 8'h00, 4'b1000, 1'b0, 1'b0, 1'b1, "R6");
        drive(8'h81, 8'h00, 4'b1000, 1'b0, 1'b1, 1'b0, "R6");
        drive(8'h81, 8'h00, 4'b1100, 1'b0, 1'b1, 1'b0, "R7");
        drive(8'h81, 8'h00, 4'b1100, 1'b0, 1'b0, 1'b1, "R7");
        // R8 carry input set in logic/shift modes must give no carry and no change.
        drive(8'hFF, 8'hFF, 4'b0101, 1'b1, 1'b0, 1'b0, "R8");
        drive(8'hFF, 8'h00, 4'b1010, 1'b1, 1'b0, 1'b0, "R8");
        drive(8'hFF, 8'h00, 4'b1111, 1'b1, 1'b0, 1'b0, "R8");
        // R9 fills toggled in arithmetic and logic modes have no effect.
        drive(8'h12, 8'h34, 4'b0000, 1'b0, 1'b1, 1'b1, "R9");
        drive(8'hFF, 8'h00, 4'b0011, 1'b1, 1'b1, 1'b1, "R9");
        drive(8'h12, 8'h34, 4'b0110, 1'b0, 1'b1, 1'b1, "R9");
        // Sweep every select, carry and fill combination with varied operands.
        for (int k = 0; k < 512; k++) begin
            logic [WIDTH-1:0] ra;
            logic [WIDTH-1:0] rb;
            ra = (k % 37 == 0) ? 8'h00 : (k % 41 == 0) ? 8'hFF : WIDTH'($urandom);
            rb = (k % 43 == 0) ? 8'hFF : WIDTH'($urandom);
            drive(ra, rb, 4'(k), k[4], k[5], k[6], "");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule